// File: doc/BRIEF.md
# Stretch-Aware I2C Clock Generator

This block produces the SCL clock of an I2C master. Software-visible settings give the length of the low phase and of the high phase in system clock cycles. The block pulls the open-drain SCL line low or lets it go. It reads the line back through a two-stage synchroniser, and each phase count starts only once the line has been seen at the level of that phase.

A slave that holds SCL low after the master releases it delays the high phase. A slow rise or fall on the bus delays the phases in the same way. Neither case raises an error, and the block applies no compensation for either delay.

A bit-level sequencer uses the one-cycle `low_done` and `high_done` strobes to move data at the right points in each bit. The `stretching` output shows when the master has released SCL but the synchronised line still reads low.

Top module: `scl_clock_gen`

## Requirements
- R1: In the definitions below, L = max(low_cycles,1), H = max(high_cycles,1), and S is the number of extra falling system clock edges that the bus stays low after the master releases it. The SCL input is synchronised through two flops, and the low count starts only after the synchronised level reads low. With a bus that follows the drive half a cycle later, `scl_pull_low` (1 = pull the line low) therefore stays asserted for exactly L+3 consecutive cycles.
- R2: When the low count completes, the block releases SCL. In the first released cycle, `low_done` is 1 for exactly one cycle.
- R3: The high count starts only after the synchronised SCL reads high, not when the line is released. SCL stays released for H+S+3 cycles. Of those released cycles, the line reads high in H+2 of them.
- R4: `stretching` is 1 only while SCL is released and the synchronised level is low. In each released phase this lasts S+2 cycles.
- R5: `high_done` is 1 for exactly one cycle, in the first cycle of renewed pull-low. The two strobes never pulse at any other time and are never 1 together.
- R6: A programmed count of 0 behaves exactly like a count of 1.
- R7: When `enable` is 0, on the next cycle SCL is released and all three status outputs (`low_done`, `high_done`, `stretching`) are 0. Both counters return to idle, so the first low phase after re-enable again lasts L+3 cycles.
- R8: During and just after reset, `scl_pull_low`, `low_done`, `high_done` and `stretching` are all 0.
- R9: One full SCL period is L+H+S+6 system cycles. Bus delays add to this period without any correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the clock generator when 1 |
| low_cycles | input | 8 | Low-phase length in system cycles (0 behaves as 1) |
| high_cycles | input | 8 | High-phase length in system cycles (0 behaves as 1) |
| scl_in | input | 1 | Level read back from the SCL pad |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| low_done | output | 1 | One-cycle strobe at the end of the low phase |
| high_done | output | 1 | One-cycle strobe at the end of the high phase |
| stretching | output | 1 | Released but the line still reads low |

## Verification
The counter-range assertion assumes that `low_cycles` and `high_cycles` do not change while their phase is counting. The bench changes them only while `enable` is low and the block is idle. The phase-length relations assume a bus that returns the driven level after half a cycle plus a bounded stretch. The bench bus model produces exactly that: it updates on the falling edge and holds the line low for a randomly chosen stretch of 0 to 5 cycles after each release. Before any re-enable, the bench also lets the bus and synchroniser settle high, so the first low phase is not shortened by a stale low level.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  localparam int unsigned TIME_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_LOW_WAIT  = 3'd1,
    PH_LOW_CNT   = 3'd2,
    PH_HIGH_WAIT = 3'd3,
    PH_HIGH_CNT  = 3'd4
  } phase_e;

endpackage

// File: rtl/scl_level_sync.sv
module scl_level_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = din;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         last
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] lim_eff;
  logic         cnt_en;

  always_comb begin
    lim_eff = (limit == '0) ? ONE : limit;
    last    = run && (cnt_q == (lim_eff - ONE));
  end

  always_comb begin
    cnt_en = 1'b1;
    if (!run)      cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + ONE;
    if (!run && cnt_q == '0) cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < lim_eff));

  assert_idle_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_sync,
  input  logic low_last,
  input  logic high_last,
  output logic low_run,
  output logic high_run,
  output logic pull_low,
  output logic low_done,
  output logic high_done,
  output logic stretching
);

  phase_e phase_q, phase_d;
  logic   pull_q, pull_d;
  logic   ldone_q, ldone_d;
  logic   hdone_q, hdone_d;

  always_comb begin
    phase_d = phase_q;
    ldone_d = 1'b0;
    hdone_d = 1'b0;
    if (!enable) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:      phase_d = PH_LOW_WAIT;
        PH_LOW_WAIT:  if (!scl_sync) phase_d = PH_LOW_CNT;
        PH_LOW_CNT:   if (low_last) begin
                        phase_d = PH_HIGH_WAIT;
                        ldone_d = 1'b1;
                      end
        PH_HIGH_WAIT: if (scl_sync) phase_d = PH_HIGH_CNT;
        PH_HIGH_CNT:  if (high_last) begin
                        phase_d = PH_LOW_WAIT;
                        hdone_d = 1'b1;
                      end
        default:      phase_d = PH_IDLE;
      endcase
    end
    pull_d = (phase_d == PH_LOW_WAIT) || (phase_d == PH_LOW_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pull_q  <= 1'b0;
      ldone_q <= 1'b0;
      hdone_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pull_q  <= pull_d;
      ldone_q <= ldone_d;
      hdone_q <= hdone_d;
    end
  end

  assign low_run    = (phase_q == PH_LOW_CNT);
  assign high_run   = (phase_q == PH_HIGH_CNT);
  assign pull_low   = pull_q;
  assign low_done   = ldone_q;
  assign high_done  = hdone_q;
  assign stretching = (phase_q == PH_HIGH_WAIT) && !scl_sync;

  assert_low_waits_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW_WAIT && scl_sync) |=> (phase_q != PH_LOW_CNT));

  assert_release_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run && low_last && enable) |=> (!pull_low && low_done));

  assert_high_waits_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH_WAIT && !scl_sync) |=> (phase_q != PH_HIGH_CNT));

  assert_stretch_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stretching |-> !pull_low);

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_done, high_done}));

  assert_high_done_pulls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    high_done |-> (pull_low && $rose(pull_low)));

  assert_disable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase_q == PH_IDLE && !pull_low && !low_done && !high_done));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned CNT_W       = TIME_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] low_cycles,
  input  logic [CNT_W-1:0] high_cycles,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             low_done,
  output logic             high_done,
  output logic             stretching
);

  logic scl_sync;
  logic low_run, high_run;
  logic low_last, high_last;

  scl_level_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (scl_in),
    .dout  (scl_sync)
  );

  scl_phase_timer #(.W(CNT_W)) u_low_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (low_run),
    .limit (low_cycles),
    .last  (low_last)
  );

  scl_phase_timer #(.W(CNT_W)) u_high_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (high_run),
    .limit (high_cycles),
    .last  (high_last)
  );

  scl_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_sync   (scl_sync),
    .low_last   (low_last),
    .high_last  (high_last),
    .low_run    (low_run),
    .high_run   (high_run),
    .pull_low   (scl_pull_low),
    .low_done   (low_done),
    .high_done  (high_done),
    .stretching (stretching)
  );

  assert_timers_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_run && high_run));

endmodule

// File: tb/tb_scl_clock_gen.sv
module tb_scl_clock_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [7:0] low_cycles, high_cycles;
  logic       scl_in;
  logic       scl_pull_low, low_done, high_done, stretching;

  int errors = 0;
  int checks = 0;
  int stretch_cfg = 0;
  int hold = 0;
  logic bus_low = 1'b0;

  always #2 clk = ~clk;

  assign scl_in = ~bus_low;

  scl_clock_gen dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .low_cycles   (low_cycles),
    .high_cycles  (high_cycles),
    .scl_in       (scl_in),
    .scl_pull_low (scl_pull_low),
    .low_done     (low_done),
    .high_done    (high_done),
    .stretching   (stretching)
  );

  // open-drain bus: follows the drive on the falling edge, slave holds low S edges
  initial begin
    forever begin
      @(negedge clk);
      if (scl_pull_low) begin
        hold    = stretch_cfg;
        bus_low = 1'b1;
      end else if (hold > 0) begin
        hold    = hold - 1;
        bus_low = 1'b1;
      end else begin
        bus_low = 1'b0;
      end
    end
  end

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #1;
  endtask

  task automatic run_phases(input int lo, input int hi, input int s, input int nph);
    int L, H;
    L = eff(lo);
    H = eff(hi);
    low_cycles  = lo[7:0];
    high_cycles = hi[7:0];
    stretch_cfg = s;
    enable      = 1'b1;
    sample();
    chk(scl_pull_low == 1'b1, "R7 pull starts after enable", int'(scl_pull_low), 1);
    for (int ph = 0; ph < nph; ph++) begin
      int nlow, nrel, nstr, nbh, stray;
      bit first;
      nlow = 0; stray = 0; first = 1'b1;
      while (scl_pull_low) begin
        nlow++;
        if (low_done || (high_done && !first)) stray++;
        first = 1'b0;
        sample();
      end
      chk(nlow == L + 3, (lo == 0) ? "R1 R6 low drive length" : "R1 low drive length", nlow, L + 3);
      chk(low_done == 1'b1, "R2 low_done at release", int'(low_done), 1);
      nrel = 0; nstr = 0; nbh = 0; first = 1'b1;
      while (!scl_pull_low) begin
        nrel++;
        if (stretching) nstr++;
        if (!bus_low) nbh++;
        if (high_done || (low_done && !first)) stray++;
        first = 1'b0;
        sample();
      end
      chk(nrel == H + s + 3, (hi == 0) ? "R3 R6 released length" : "R3 released length", nrel, H + s + 3);
      chk(nbh == H + 2, "R3 high level cycles", nbh, H + 2);
      chk(nstr == s + 2, "R4 stretching cycles", nstr, s + 2);
      chk(high_done == 1'b1, "R5 high_done at pull", int'(high_done), 1);
      chk(stray == 0, "R5 stray strobes", stray, 0);
      chk(nlow + nrel == L + H + s + 6, "R9 period", nlow + nrel, L + H + s + 6);
    end
  endtask

  task automatic disable_after(input int wait_cycles);
    for (int i = 0; i < wait_cycles; i++) sample();
    enable = 1'b0;
    sample();
    chk(scl_pull_low == 1'b0, "R7 released when disabled", int'(scl_pull_low), 0);
    chk(!low_done && !high_done && !stretching, "R7 status cleared",
        int'({low_done, high_done, stretching}), 0);
    for (int i = 0; i < 12; i++) sample();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_val;
    rst_n       = 1'b0;
    enable      = 1'b0;
    low_cycles  = 8'd0;
    high_cycles = 8'd0;
    seed_val = $urandom(32'h5eed);
    repeat (3) sample();
    chk(!scl_pull_low && !low_done && !high_done && !stretching, "R8 reset outputs",
        int'({scl_pull_low, low_done, high_done, stretching}), 0);
    rst_n = 1'b1;
    repeat (3) sample();
    chk(!scl_pull_low && !low_done && !high_done && !stretching, "R8 idle after reset",
        int'({scl_pull_low, low_done, high_done, stretching}), 0);

    // directed corners
    run_phases(0, 0, 0, 2);   disable_after(0);
    run_phases(1, 1, 0, 2);   disable_after(1);
    run_phases(3, 4, 5, 2);   disable_after(2);
    run_phases(5, 0, 3, 2);   disable_after(4);
    run_phases(255, 2, 1, 1); disable_after(7);

    // constrained random
    for (int n = 0; n < 14; n++) begin
      int lo, hi, s;
      lo = int'($urandom_range(0, 12));
      hi = int'($urandom_range(0, 12));
      s  = int'($urandom_range(0, 5));
      run_phases(lo, hi, s, 3);
      disable_after(int'($urandom_range(0, 9)));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule